// File: doc/BRIEF.md
# Two-Requester Priority Memory Arbiter

This block lets two clients share one single-port synchronous memory of 32768 rows of 256 bits. Each client hands its requests over through the read side of a first-word-fall-through FIFO: an empty flag, the head word and a pop strobe. Read results go back through the write side of a FIFO per client: a full flag, a data word and a push strobe. The command client may read or write. The event client may only read. When both have work, the command client always wins.

A write costs one cycle and sends no reply. A read presents the row address, holds it through a fixed number of wait cycles that match the memory's read latency (three by default), and in the last wait cycle pushes a reply made of the address and the row contents to the client that asked. The request stays at the head of its FIFO until that reply is pushed. If the reply FIFO is full, the block waits in the last wait cycle for as long as it takes, with the address held.

Top module: `shared_row_arbiter`

## Requirements
- R1: The reset input is active low and sampled on the clock edge. While it is low, and for one cycle after it rises, both pops, both pushes and the memory write enable are 0.
- R2: A command word uses bit 271 as the operation (1 = write, 0 = read), bits 270:256 as the row address and bits 255:0 as the write data. An idle block that accepts a write drives that address and data, raises the memory write enable and the command pop in the same cycle, and is idle again in the next cycle, so back-to-back writes run at one per cycle.
- R3: When both request FIFOs are non-empty in the idle state, the command request is served first. The event request starts only in an idle cycle in which the command FIFO is empty.
- R4: A read drives its row address from the idle cycle and holds it unchanged through three wait cycles. With space in the reply FIFO, the reply is pushed in the third wait cycle, three cycles after the idle cycle that accepted the request.
- R5: A reply is 271 bits wide: the request's row address in bits 270:256 and the row contents read from memory in bits 255:0.
- R6: Each reply goes only to the reply FIFO of the client that asked. A request FIFO is popped in the cycle its reply is pushed (or, for a command write, the cycle the write is done), and at no other time.
- R7: While the target reply FIFO is full, the block stays in the last wait cycle with the address held and pushes nothing. It pushes in the first such cycle in which the full flag is low. There is no timeout.
- R8: The memory write enable is raised only for command writes, never during a read or for an event request.
- R9: Replies to each client come back in the order of that client's requests, and a read after a write to the same row returns the written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_req_empty | input | 1 | Command request FIFO is empty |
| cmd_req_data | input | 272 | Command request FIFO head word |
| cmd_req_pop | output | 1 | Pop the command request FIFO |
| cmd_rsp_full | input | 1 | Command reply FIFO is full |
| cmd_rsp_data | output | 271 | Reply word for the command client |
| cmd_rsp_push | output | 1 | Push into the command reply FIFO |
| evt_req_empty | input | 1 | Event request FIFO is empty |
| evt_req_addr | input | 15 | Event request FIFO head (row address) |
| evt_req_pop | output | 1 | Pop the event request FIFO |
| evt_rsp_full | input | 1 | Event reply FIFO is full |
| evt_rsp_data | output | 271 | Reply word for the event client |
| evt_rsp_push | output | 1 | Push into the event reply FIFO |
| mem_addr | output | 15 | Memory row address |
| mem_wdata | output | 256 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 256 | Memory read data, valid three cycles after the address |

## Verification
A wait counter that is off by one shows at the reply port in the very transaction where it occurs: the reply comes one cycle early or late, and its data is the previous or next value of the memory pipeline rather than the addressed row. A wrong owner bit sends the reply to the other client's FIFO, so it is seen at once as an unexpected or mis-addressed reply. A state register that fails to return to idle shows within a few cycles as a reply that never comes or a request FIFO that is never popped. Mixed write-then-read traffic to the same row, with both clients active, shows priority or ordering faults as stale data.

// File: rtl/arb_pkg.sv
// Shared types for the two-requester memory arbiter.
package arb_pkg;
    typedef enum logic [1:0] {
        ST_RST  = 2'd0,
        ST_IDLE = 2'd1,
        ST_WAIT = 2'd2
    } arb_state_e;

    typedef enum logic {
        SRC_CMD = 1'b0,
        SRC_EVT = 1'b1
    } arb_src_e;
endpackage

// File: rtl/arb_pick.sv
// Fixed-priority request selector.
// Chooses what an idle arbiter starts this cycle: a command write, a
// command read, or an event read. The command side always wins.
// Assumes: purely combinational; the caller only acts on it when idle.
module arb_pick
    import arb_pkg::*;
(
    input  logic     cmd_valid,
    input  logic     cmd_write,
    input  logic     evt_valid,
    output logic     go_read,
    output logic     go_write,
    output arb_src_e go_src
);
    // Priority decision: command first, event only when command is empty.
    always_comb begin
        go_read  = 1'b0;
        go_write = 1'b0;
        go_src   = SRC_CMD;
        if (cmd_valid) begin
            if (cmd_write) go_write = 1'b1;
            else           go_read  = 1'b1;
        end else if (evt_valid) begin
            go_read = 1'b1;
            go_src  = SRC_EVT;
        end
    end
endmodule

// File: rtl/arb_seq.sv
// Transaction sequencer.
// Tracks reset / idle / wait, the client that owns the current read, and
// counts RD_LAT wait cycles. The last wait cycle repeats until the reply
// FIFO has space.
// Assumes: RD_LAT >= 1; go_read and go_src are only meaningful when idle.
module arb_seq
    import arb_pkg::*;
#(
    parameter int RD_LAT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_read,
    input  arb_src_e   go_src,
    input  logic       rsp_space,
    output arb_state_e state,
    output arb_src_e   owner,
    output logic       in_last
);
    localparam int CNT_W = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(RD_LAT - 1);

    logic [CNT_W-1:0] wcnt;

    // Final wait cycle: memory data is valid here.
    assign in_last = (state == ST_WAIT) && (wcnt == LAST_CNT);

    // State, owner and wait counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RST;
            owner <= SRC_CMD;
            wcnt  <= '0;
        end else begin
            case (state)
                ST_RST:  state <= ST_IDLE;
                ST_IDLE: if (go_read) begin
                    state <= ST_WAIT;
                    owner <= go_src;
                    wcnt  <= '0;
                end
                ST_WAIT: begin
                    if (!in_last)       wcnt  <= wcnt + 1'b1;
                    else if (rsp_space) state <= ST_IDLE;
                end
                default: state <= ST_RST;
            endcase
        end
    end
endmodule

// File: rtl/arb_route.sv
// Address mux, strobe generation and reply formation.
// Picks the head address of the client being served, raises the memory
// write enable for command writes, and pairs each reply push with the pop
// of the matching request FIFO.
// Assumes: idle and in_last are already forced low during reset.
module arb_route
    import arb_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 256
) (
    input  logic                     idle,
    input  logic                     in_last,
    input  logic                     rsp_space,
    input  logic                     go_write,
    input  arb_src_e                 go_src,
    input  arb_src_e                 owner,
    input  logic [ADDR_W-1:0]        cmd_addr,
    input  logic [ADDR_W-1:0]        evt_addr,
    input  logic [DATA_W-1:0]        rdata,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_we,
    output logic                     cmd_pop,
    output logic                     evt_pop,
    output logic                     cmd_push,
    output logic                     evt_push,
    output logic [ADDR_W+DATA_W-1:0] rsp_word
);
    arb_src_e sel_src;
    logic     retire;

    // Source of the address: new choice when idle, owner while waiting.
    assign sel_src  = idle ? go_src : owner;
    assign mem_addr = (sel_src == SRC_EVT) ? evt_addr : cmd_addr;

    // Strobes: write in idle, reply plus pop in the final wait cycle.
    assign retire   = in_last && rsp_space;
    assign mem_we   = idle && go_write;
    assign cmd_push = retire && (owner == SRC_CMD);
    assign evt_push = retire && (owner == SRC_EVT);
    assign cmd_pop  = mem_we || cmd_push;
    assign evt_pop  = evt_push;

    // Reply word: echoed address above the row contents.
    assign rsp_word = {mem_addr, rdata};
endmodule

// File: rtl/shared_row_arbiter.sv
// Two-requester priority arbiter for one single-port synchronous memory.
// The command client reads and writes; the event client only reads. A
// write completes in one idle cycle. A read holds its address for RD_LAT
// wait cycles and replies in the last one, stalling there while the reply
// FIFO is full. Request FIFOs are popped only when their work is done.
// Assumes: first-word-fall-through request FIFOs whose head stays stable
// until popped; memory read data valid RD_LAT cycles after the address.
module shared_row_arbiter
    import arb_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 256,
    parameter int RD_LAT = 3,
    localparam int REQ_W = ADDR_W + DATA_W + 1,
    localparam int RSP_W = ADDR_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_req_empty,
    input  logic [REQ_W-1:0]  cmd_req_data,
    output logic              cmd_req_pop,
    input  logic              cmd_rsp_full,
    output logic [RSP_W-1:0]  cmd_rsp_data,
    output logic              cmd_rsp_push,
    input  logic              evt_req_empty,
    input  logic [ADDR_W-1:0] evt_req_addr,
    output logic              evt_req_pop,
    input  logic              evt_rsp_full,
    output logic [RSP_W-1:0]  evt_rsp_data,
    output logic              evt_rsp_push,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata
);
    arb_state_e        state;
    arb_src_e          owner;
    arb_src_e          go_src;
    logic              go_read, go_write;
    logic              in_last, seq_last, idle, rsp_space;
    logic              cmd_is_write;
    logic [ADDR_W-1:0] cmd_addr;
    logic [RSP_W-1:0]  rsp_word;

    // Field split of the command word.
    assign cmd_is_write = cmd_req_data[REQ_W-1];
    assign cmd_addr     = cmd_req_data[REQ_W-2:DATA_W];
    assign mem_wdata    = cmd_req_data[DATA_W-1:0];

    // Qualifiers forced low while reset is held.
    assign idle      = rst_n && (state == ST_IDLE);
    assign in_last   = rst_n && seq_last;
    assign rsp_space = (owner == SRC_EVT) ? !evt_rsp_full : !cmd_rsp_full;

    arb_pick u_pick (
        .cmd_valid (!cmd_req_empty),
        .cmd_write (cmd_is_write),
        .evt_valid (!evt_req_empty),
        .go_read   (go_read),
        .go_write  (go_write),
        .go_src    (go_src)
    );

    arb_seq #(.RD_LAT(RD_LAT)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_read   (go_read),
        .go_src    (go_src),
        .rsp_space (rsp_space),
        .state     (state),
        .owner     (owner),
        .in_last   (seq_last)
    );

    arb_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_route (
        .idle      (idle),
        .in_last   (in_last),
        .rsp_space (rsp_space),
        .go_write  (go_write),
        .go_src    (go_src),
        .owner     (owner),
        .cmd_addr  (cmd_addr),
        .evt_addr  (evt_req_addr),
        .rdata     (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .cmd_pop   (cmd_req_pop),
        .evt_pop   (evt_req_pop),
        .cmd_push  (cmd_rsp_push),
        .evt_push  (evt_rsp_push),
        .rsp_word  (rsp_word)
    );

    // Both reply ports carry the same word; only the strobe differs.
    assign cmd_rsp_data = rsp_word;
    assign evt_rsp_data = rsp_word;
endmodule

// File: rtl/arb_chk.sv
// Protocol checker for shared_row_arbiter, attached with bind.
// Watches strobes, the sequencer state and the echoed address.
// Assumes: request FIFO heads stay stable until popped.
module arb_chk
    import arb_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input arb_state_e        state,
    input arb_src_e          owner,
    input logic              cmd_req_empty,
    input logic              evt_req_empty,
    input logic              cmd_req_pop,
    input logic              evt_req_pop,
    input logic              cmd_rsp_push,
    input logic              evt_rsp_push,
    input logic              cmd_rsp_full,
    input logic              evt_rsp_full,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] cmd_req_addr,
    input logic [ADDR_W-1:0] cmd_rsp_addr,
    input logic [ADDR_W-1:0] evt_req_addr,
    input logic [ADDR_W-1:0] evt_rsp_addr
);
    // R1: no strobe in the reset state
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RST) |-> !(mem_we || cmd_req_pop || evt_req_pop || cmd_rsp_push || evt_rsp_push));

    // R2: a write pops the command FIFO and leaves the block idle
    p_write_pops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (cmd_req_pop && !cmd_req_empty));
    p_write_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (state == ST_IDLE));

    // R3: with both FIFOs loaded, the event side does not take ownership
    p_cmd_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !cmd_req_empty && !evt_req_empty) |=> (state == ST_IDLE || owner == SRC_CMD));

    // R4: address held through the wait cycles
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> $stable(mem_addr));

    // R5: replies echo the request address
    p_cmd_echo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rsp_push |-> (cmd_rsp_addr == cmd_req_addr));
    p_evt_echo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rsp_push |-> (evt_rsp_addr == evt_req_addr));

    // R6: event pop only together with its reply
    p_evt_pop_paired_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_req_pop |-> evt_rsp_push);

    // R7: never push into a full FIFO
    p_cmd_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rsp_push |-> !cmd_rsp_full);
    p_evt_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rsp_push |-> !evt_rsp_full);

    // R8: at most one memory or reply action per cycle; no write while reading
    p_one_action_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, cmd_rsp_push, evt_rsp_push}));
    p_no_write_in_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !mem_we);
endmodule

bind shared_row_arbiter arb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state),
    .owner         (owner),
    .cmd_req_empty (cmd_req_empty),
    .evt_req_empty (evt_req_empty),
    .cmd_req_pop   (cmd_req_pop),
    .evt_req_pop   (evt_req_pop),
    .cmd_rsp_push  (cmd_rsp_push),
    .evt_rsp_push  (evt_rsp_push),
    .cmd_rsp_full  (cmd_rsp_full),
    .evt_rsp_full  (evt_rsp_full),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .cmd_req_addr  (cmd_req_data[ADDR_W+DATA_W-1:DATA_W]),
    .cmd_rsp_addr  (cmd_rsp_data[ADDR_W+DATA_W-1:DATA_W]),
    .evt_req_addr  (evt_req_addr),
    .evt_rsp_addr  (evt_rsp_data[ADDR_W+DATA_W-1:DATA_W])
);

// File: tb/shared_row_arbiter_tb.sv
module shared_row_arbiter_tb;
    localparam int AW = 15;
    localparam int DW = 256;
    localparam int REQW = AW + DW + 1;
    localparam int RSPW = AW + DW;
    localparam int NVEC = 13;
    // Vector: [31] write, [30:16] row, [15:0] data seed repeated 16 times
    localparam logic [31:0] VEC [0:NVEC-1] = '{
        32'h8000_1111, 32'hFFFF_2222, 32'h0000_0000, 32'h7FFF_0000,
        32'h0555_0000, 32'h8555_3333, 32'h0555_0000, 32'h9234_4444,
        32'h9234_5555, 32'h1234_0000, 32'h0123_0000, 32'h8000_6666,
        32'h0000_0000
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic            cmd_req_empty, cmd_req_pop, cmd_rsp_full, cmd_rsp_push;
    logic [REQW-1:0] cmd_req_data;
    logic [RSPW-1:0] cmd_rsp_data, evt_rsp_data;
    logic            evt_req_empty, evt_req_pop, evt_rsp_full, evt_rsp_push;
    logic [AW-1:0]   evt_req_addr, mem_addr;
    logic [DW-1:0]   mem_wdata, mem_rdata;
    logic            mem_we;

    shared_row_arbiter u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_req_empty(cmd_req_empty), .cmd_req_data(cmd_req_data), .cmd_req_pop(cmd_req_pop),
        .cmd_rsp_full(cmd_rsp_full), .cmd_rsp_data(cmd_rsp_data), .cmd_rsp_push(cmd_rsp_push),
        .evt_req_empty(evt_req_empty), .evt_req_addr(evt_req_addr), .evt_req_pop(evt_req_pop),
        .evt_rsp_full(evt_rsp_full), .evt_rsp_data(evt_rsp_data), .evt_rsp_push(evt_rsp_push),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    int nchk = 0, nfail = 0, cyc = 0, n_we = 0, nwr = 0;

    // ---------------- behavioural memory, 3-cycle read latency -------------
    logic [DW-1:0] mem_arr [int];
    logic [DW-1:0] shadow [int];
    logic [DW-1:0] pipe1, pipe2, pipe3;

    function automatic logic [DW-1:0] fill_val(input logic [AW-1:0] a);
        return {16{a, 1'b1}};
    endfunction
    function automatic logic [DW-1:0] mem_peek(input logic [AW-1:0] a);
        if (mem_arr.exists(int'(a))) return mem_arr[int'(a)];
        return fill_val(a);
    endfunction
    function automatic logic [DW-1:0] shadow_rd(input logic [AW-1:0] a);
        if (shadow.exists(int'(a))) return shadow[int'(a)];
        return fill_val(a);
    endfunction

    always @(posedge clk) begin
        pipe1 <= mem_peek(mem_addr);
        pipe2 <= pipe1;
        pipe3 <= pipe2;
        if (mem_we) mem_arr[int'(mem_addr)] = mem_wdata;
        cyc <= cyc + 1;
    end
    assign mem_rdata = pipe3;

    // ---------------- request FIFOs (fall-through) ---------------------------
    logic [REQW-1:0] cq [0:63];
    logic [AW-1:0]   eq [0:63];
    int cwp = 0, crp = 0, ewp = 0, erp = 0;
    assign cmd_req_empty = (crp == cwp);
    assign cmd_req_data  = cq[crp % 64];
    assign evt_req_empty = (erp == ewp);
    assign evt_req_addr  = eq[erp % 64];
    always @(posedge clk) begin
        if (cmd_req_pop) crp <= crp + 1;
        if (evt_req_pop) erp <= erp + 1;
    end

    // ---------------- expected replies --------------------------------------
    logic [RSPW-1:0] exp_c [0:63];
    logic [RSPW-1:0] exp_e [0:63];
    int c_cyc [0:63];
    int e_cyc [0:63];
    int ecw = 0, ecr = 0, eew = 0, eer = 0;

    task automatic chk(input bit ok, input string tag, input logic [RSPW-1:0] act, input logic [RSPW-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put_cmd(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        cq[cwp % 64] = {wr, a, d};
        cwp++;
        if (wr) begin
            shadow[int'(a)] = d;
            nwr++;
        end else begin
            exp_c[ecw % 64] = {a, shadow_rd(a)};
            ecw++;
        end
    endtask

    task automatic put_evt(input logic [AW-1:0] a);
        eq[ewp % 64] = a;
        ewp++;
        exp_e[eew % 64] = {a, shadow_rd(a)};
        eew++;
    endtask

    // Reply monitor, sampled away from the clock edge
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (mem_we) n_we++;
            if (cmd_rsp_push) begin
                chk(ecr < ecw && cmd_rsp_data === exp_c[ecr % 64], "R5 R6 R9 command reply", cmd_rsp_data, exp_c[ecr % 64]);
                c_cyc[ecr % 64] = cyc;
                ecr++;
            end
            if (evt_rsp_push) begin
                chk(eer < eew && evt_rsp_data === exp_e[eer % 64], "R5 R6 R9 event reply", evt_rsp_data, exp_e[eer % 64]);
                e_cyc[eer % 64] = cyc;
                eer++;
            end
            if (cmd_req_pop && !cmd_rsp_push && !mem_we) chk(1'b0, "R6 command pop without work done", 1, 0);
            if (evt_req_pop && !evt_rsp_push) chk(1'b0, "R6 event pop without reply", 1, 0);
            if (cmd_rsp_push && cmd_rsp_full) chk(1'b0, "R7 push into full command FIFO", 1, 0);
            if (evt_rsp_push && evt_rsp_full) chk(1'b0, "R7 push into full event FIFO", 1, 0);
        end
    end

    task automatic drain();
        int n = 0;
        while ((ecr != ecw || eer != eew || crp != cwp || erp != ewp) && n < 400) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        chk(n < 400, "R9 all replies delivered", n, 400);
    endtask

    // Watchdog
    initial begin
        #(20 * 100000);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int t0, cb, eb;
        cmd_rsp_full = 1'b0;
        evt_rsp_full = 1'b0;

        // R1: write queued during reset must wait
        @(negedge clk);
        put_cmd(1'b1, 15'h0123, {8{32'hA5A5_0001}});
        repeat (2) @(negedge clk);
        #3 chk(!mem_we && !cmd_req_pop && !cmd_rsp_push && !evt_rsp_push, "R1 strobes low in reset", mem_we, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #3 chk(!mem_we && !cmd_req_pop, "R1 strobes low in cycle after reset", mem_we, 0);
        @(negedge clk);
        #3 chk(mem_we && cmd_req_pop && mem_addr == 15'h0123 && mem_wdata == {8{32'hA5A5_0001}},
               "R2 write done one cycle after reset state", {mem_we, cmd_req_pop, mem_addr}, {2'b11, 15'h0123});

        // R9 R2 R5: command vector table
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            put_cmd(VEC[i][31], VEC[i][30:16], {16{VEC[i][15:0]}});
        end
        drain();

        // R2: three writes back to back, one per cycle
        @(negedge clk);
        put_cmd(1'b1, 15'h0200, {16{16'hC001}});
        put_cmd(1'b1, 15'h0201, {16{16'hC002}});
        put_cmd(1'b1, 15'h0202, {16{16'hC003}});
        for (int k = 0; k < 3; k++) begin
            #3 chk(mem_we && mem_addr == 15'(16'h0200 + k), "R2 back-to-back writes", {mem_we, mem_addr}, {1'b1, 15'(16'h0200 + k)});
            @(negedge clk);
        end
        drain();

        // R4: command read latency
        @(negedge clk);
        put_cmd(1'b0, 15'h0201, '0);
        t0 = cyc;
        drain();
        chk(c_cyc[(ecr - 1) % 64] - t0 == 3, "R4 command read reply cycle", c_cyc[(ecr - 1) % 64] - t0, 3);

        // R4: event read latency
        @(negedge clk);
        put_evt(15'h0202);
        t0 = cyc;
        drain();
        chk(e_cyc[(eer - 1) % 64] - t0 == 3, "R4 event read reply cycle", e_cyc[(eer - 1) % 64] - t0, 3);

        // R3: both clients loaded together; command reads first
        @(negedge clk);
        cb = ecw;
        eb = eew;
        put_cmd(1'b0, 15'h0010, '0);
        put_cmd(1'b0, 15'h0011, '0);
        put_cmd(1'b0, 15'h0012, '0);
        put_evt(15'h0020);
        put_evt(15'h0021);
        t0 = cyc;
        drain();
        chk(c_cyc[cb % 64] - t0 == 3 && c_cyc[(cb + 2) % 64] - t0 == 11, "R3 command reads served first",
            c_cyc[(cb + 2) % 64] - t0, 11);
        chk(e_cyc[eb % 64] - t0 == 15 && e_cyc[(eb + 1) % 64] - t0 == 19, "R3 event reads after command FIFO empties",
            e_cyc[eb % 64] - t0, 15);

        // R3 R8: command write and event read to one row, queued together
        @(negedge clk);
        put_cmd(1'b1, 15'h0030, {16{16'hBEEF}});
        put_evt(15'h0030);
        #3 chk(mem_we && !evt_req_pop, "R3 write wins over pending event read", {mem_we, evt_req_pop}, 2'b10);
        drain();

        // R7: event reply FIFO full stalls the block
        evt_rsp_full = 1'b1;
        @(negedge clk);
        eb = eer;
        put_evt(15'h7FFF);
        put_cmd(1'b0, 15'h0000, '0);
        repeat (8) @(negedge clk);
        #3 chk(!evt_rsp_push && !evt_req_pop && !cmd_req_pop && mem_addr == 15'h7FFF && eer == eb,
               "R7 stalled in last wait cycle", {evt_rsp_push, mem_addr}, {1'b0, 15'h7FFF});
        @(negedge clk);
        evt_rsp_full = 1'b0;
        #3 chk(evt_rsp_push && evt_req_pop && evt_rsp_data == {15'h7FFF, {16{16'h2222}}},
               "R7 reply pushed once space appears", evt_rsp_data, {15'h7FFF, {16{16'h2222}}});
        drain();

        // R7: command reply FIFO full for a shorter stall
        cmd_rsp_full = 1'b1;
        @(negedge clk);
        put_cmd(1'b0, 15'h0555, '0);
        repeat (5) @(negedge clk);
        #3 chk(!cmd_rsp_push && !cmd_req_empty, "R7 command reply held while full", cmd_rsp_push, 0);
        @(negedge clk);
        cmd_rsp_full = 1'b0;
        drain();

        // R8: write enable count matches the number of command writes
        chk(n_we == nwr, "R8 write enable only for command writes", n_we, nwr);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule